// File: doc/BRIEF.md
# Byte-Lane Data Watchpoint Comparator

This block watches the data of load and store cycles on a 32-bit bus. Two comparators, called G and H, check the bus data against their own programmed reference values. Each comparator is split into four byte comparators. Each byte has its own mask bit. Depending on the programmed compare size, the per-byte results are used as they are (byte mode) or chained into half-word or full-word results. The chaining also depends on a signed or unsigned setting. The programmed compare type then turns each result into a match for each byte lane.

A lane match is kept only when that lane carries valid data for the current cycle. Valid lanes follow from the low address bits and the cycle size. Four events are then formed from the G and H lane matches. Debug logic downstream uses these events to raise watchpoints. All outputs are registered and appear one clock after the cycle strobe.

Top module: `dwp_datacmp`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, all match and event outputs are 0.
- R2: Lane k is bus bits [31-8k:24-8k], so lane 0 is the most significant byte. In byte compare size (code 0), each lane is compared with the same byte of the reference on its own.
- R3: In half-word compare size (code 1), lanes 0–1 form one unit and lanes 2–3 form another. In word compare size (code 2 or 3), all four lanes form one unit. A unit is equal when all its bytes are equal. It is less when a more significant byte is less and every byte above that one is equal. Every lane of a unit reports the result of the unit.
- R4: When the signed setting is 1, only the most significant byte of each unit is compared in two's complement. All other bytes are compared unsigned.
- R5: A masked byte (mask bit k = 1 for lane k) counts as equal and not less, whatever its data.
- R6: Compare type code 0 matches on equal, 1 on not equal, 2 on bus data greater than the reference, and 3 on bus data less than the reference.
- R7: Valid lanes depend on the cycle size. For a byte cycle (size code 0), only the lane equal to `cyc_addr` is valid. For a half-word cycle (code 1), lanes 2·`cyc_addr[1]` and 2·`cyc_addr[1]`+1 are valid. For a word cycle (code 2 or 3), all lanes are valid. A match on a lane that is not valid is forced to 0.
- R8: If the cycle size ranks below a comparator's compare size, none of that comparator's lane matches can assert. The rank order is byte < half-word < word.
- R9: `ev_any_g` is the OR of the G matches and `ev_any_h` is the OR of the H matches. `ev_lane_both` is set when some lane has both its G and its H match set. `ev_either` is the OR of all eight matches.
- R10: Outputs update on the clock edge that samples `cyc_valid`. A cycle without `cyc_valid` yields all outputs 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | Load/store data cycle strobe |
| cyc_data | input | 32 | Bus data, lane 0 in bits 31:24 |
| cyc_addr | input | 2 | Low address bits of the cycle |
| cyc_size | input | 2 | Cycle size: 0 byte, 1 half-word, 2/3 word |
| g_ref | input | 32 | G reference value |
| g_mask | input | 4 | G byte masks, bit k masks lane k |
| g_signed | input | 1 | G signed compare |
| g_csize | input | 2 | G compare size: 0 byte, 1 half, 2/3 word |
| g_ctype | input | 2 | G compare type: 0 eq, 1 ne, 2 gt, 3 lt |
| h_ref | input | 32 | H reference value |
| h_mask | input | 4 | H byte masks |
| h_signed | input | 1 | H signed compare |
| h_csize | input | 2 | H compare size |
| h_ctype | input | 2 | H compare type |
| g_match | output | 4 | G lane matches, bit k = lane k |
| h_match | output | 4 | H lane matches, bit k = lane k |
| ev_any_g | output | 1 | Any G lane matched |
| ev_any_h | output | 1 | Any H lane matched |
| ev_lane_both | output | 1 | Some lane matched in G and in H |
| ev_either | output | 1 | Any lane matched in G or in H |

## Verification
Every result passes through exactly one register. The lane matches and the four events for a cycle driven before a rising edge are therefore all due after that same edge. The bench drives the inputs on a falling edge and compares all outputs on the next falling edge, one edge later, against an arithmetic model of the compare. A cycle without a strobe is checked at that same single-edge delay and must give all zeros.

// File: rtl/dwp_pkg.sv
package dwp_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WORD_ALT = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        CT_EQ = 2'd0,
        CT_NE = 2'd1,
        CT_GT = 2'd2,
        CT_LT = 2'd3
    } ctype_e;

    // Collapse the two word codes into one rank: 0 byte, 1 half, 2 word.
    function automatic logic [1:0] size_rank(input logic [1:0] s);
        return s[1] ? 2'd2 : s;
    endfunction

    function automatic logic type_hit(input logic [1:0] t, input logic eq, input logic lt);
        logic r;
        unique case (ctype_e'(t))
            CT_EQ:   r = eq;
            CT_NE:   r = !eq;
            CT_GT:   r = !eq && !lt;
            CT_LT:   r = lt;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dwp_byte_cmp.sv
module dwp_byte_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         mask_i,
    input  logic         sgn_i,
    output logic         eq_o,
    output logic         lt_o
);
    logic lt_raw;

    always_comb begin
        if (sgn_i) lt_raw = $signed(a_i) < $signed(b_i);
        else       lt_raw = a_i < b_i;
        eq_o = mask_i || (a_i == b_i);
        lt_o = !mask_i && lt_raw;
    end
endmodule

// File: rtl/dwp_unit_cmp.sv
module dwp_unit_cmp
    import dwp_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] data_i,
    input  logic [LANES*LANE_W-1:0] ref_i,
    input  logic [LANES-1:0]        mask_i,
    input  logic                    sgn_i,
    input  logic [1:0]              csize_i,
    input  logic [1:0]              ctype_i,
    output logic [LANES-1:0]        hit_o
);
    localparam int HALVES = LANES / 2;

    logic [1:0]        rank;
    logic [LANES-1:0]  b_eq, b_lt, msb;
    logic [HALVES-1:0] h_eq, h_lt;
    logic              w_eq, w_lt;

    assign rank = size_rank(csize_i);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int HI = (LANES - l) * LANE_W - 1;
        // Sign applies to the top byte of each merged unit only.
        assign msb[l] = (rank == 2'd0) || (rank == 2'd1 && (l % 2) == 0) || (l == 0);
        dwp_byte_cmp #(.W(LANE_W)) u_byte (
            .a_i   (data_i[HI -: LANE_W]),
            .b_i   (ref_i[HI -: LANE_W]),
            .mask_i(mask_i[l]),
            .sgn_i (sgn_i && msb[l]),
            .eq_o  (b_eq[l]),
            .lt_o  (b_lt[l])
        );
    end

    for (genvar u = 0; u < HALVES; u++) begin : g_half
        assign h_eq[u] = b_eq[2*u] && b_eq[2*u+1];
        assign h_lt[u] = b_lt[2*u] || (b_eq[2*u] && b_lt[2*u+1]);
    end

    // Lexicographic fold of the half-word results, most significant first.
    always_comb begin
        w_eq = 1'b1;
        w_lt = 1'b0;
        for (int u = 0; u < HALVES; u++) begin
            w_lt = w_lt || (w_eq && h_lt[u]);
            w_eq = w_eq && h_eq[u];
        end
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            unique case (rank)
                2'd0:    hit_o[l] = type_hit(ctype_i, b_eq[l], b_lt[l]);
                2'd1:    hit_o[l] = type_hit(ctype_i, h_eq[l/2], h_lt[l/2]);
                default: hit_o[l] = type_hit(ctype_i, w_eq, w_lt);
            endcase
        end
    end
endmodule

// File: rtl/dwp_lane_valid.sv
module dwp_lane_valid
    import dwp_pkg::*;
#(
    parameter int LANES = 4,
    localparam int AW   = $clog2(LANES)
) (
    input  logic [AW-1:0]    addr_i,
    input  logic [1:0]       cyc_size_i,
    input  logic [1:0]       csize_i,
    output logic [LANES-1:0] lanes_o
);
    logic [1:0] cyc_rank, cmp_rank;

    always_comb begin
        cyc_rank = size_rank(cyc_size_i);
        cmp_rank = size_rank(csize_i);
        for (int l = 0; l < LANES; l++) begin
            unique case (cyc_rank)
                2'd0:    lanes_o[l] = (AW'(l) == addr_i);
                2'd1:    lanes_o[l] = (AW'(l) >> 1) == (addr_i >> 1);
                default: lanes_o[l] = 1'b1;
            endcase
        end
        // A narrower access than the compare unit carries no valid match.
        if (cyc_rank < cmp_rank) lanes_o = '0;
    end
endmodule

// File: rtl/dwp_datacmp.sv
module dwp_datacmp
    import dwp_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int AW    = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_valid,
    input  logic [DATA_W-1:0] cyc_data,
    input  logic [AW-1:0]     cyc_addr,
    input  logic [1:0]        cyc_size,
    input  logic [DATA_W-1:0] g_ref,
    input  logic [LANES-1:0]  g_mask,
    input  logic              g_signed,
    input  logic [1:0]        g_csize,
    input  logic [1:0]        g_ctype,
    input  logic [DATA_W-1:0] h_ref,
    input  logic [LANES-1:0]  h_mask,
    input  logic              h_signed,
    input  logic [1:0]        h_csize,
    input  logic [1:0]        h_ctype,
    output logic [LANES-1:0]  g_match,
    output logic [LANES-1:0]  h_match,
    output logic              ev_any_g,
    output logic              ev_any_h,
    output logic              ev_lane_both,
    output logic              ev_either
);
    localparam int NCMP = 2;

    logic [DATA_W-1:0] ref_a   [NCMP];
    logic [LANES-1:0]  mask_a  [NCMP];
    logic              sgn_a   [NCMP];
    logic [1:0]        csize_a [NCMP];
    logic [1:0]        ctype_a [NCMP];
    logic [LANES-1:0]  hit_a   [NCMP];
    logic [LANES-1:0]  vld_a   [NCMP];
    logic [LANES-1:0]  lane_d  [NCMP];

    assign ref_a   = '{g_ref, h_ref};
    assign mask_a  = '{g_mask, h_mask};
    assign sgn_a   = '{g_signed, h_signed};
    assign csize_a = '{g_csize, h_csize};
    assign ctype_a = '{g_ctype, h_ctype};

    for (genvar c = 0; c < NCMP; c++) begin : g_cmp
        dwp_unit_cmp #(.LANES(LANES), .LANE_W(8)) u_unit (
            .data_i (cyc_data),
            .ref_i  (ref_a[c]),
            .mask_i (mask_a[c]),
            .sgn_i  (sgn_a[c]),
            .csize_i(csize_a[c]),
            .ctype_i(ctype_a[c]),
            .hit_o  (hit_a[c])
        );
        dwp_lane_valid #(.LANES(LANES)) u_valid (
            .addr_i    (cyc_addr),
            .cyc_size_i(cyc_size),
            .csize_i   (csize_a[c]),
            .lanes_o   (vld_a[c])
        );
        assign lane_d[c] = hit_a[c] & vld_a[c] & {LANES{cyc_valid}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_match      <= '0;
            h_match      <= '0;
            ev_any_g     <= 1'b0;
            ev_any_h     <= 1'b0;
            ev_lane_both <= 1'b0;
            ev_either    <= 1'b0;
        end else begin
            g_match      <= lane_d[0];
            h_match      <= lane_d[1];
            ev_any_g     <= |lane_d[0];
            ev_any_h     <= |lane_d[1];
            ev_lane_both <= |(lane_d[0] & lane_d[1]);
            ev_either    <= |(lane_d[0] | lane_d[1]);
        end
    end
endmodule

// File: rtl/dwp_datacmp_chk.sv
module dwp_datacmp_chk
    import dwp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cyc_valid,
    input logic [1:0] cyc_size,
    input logic [1:0] g_csize,
    input logic [1:0] h_csize,
    input logic [3:0] g_match,
    input logic [3:0] h_match,
    input logic       ev_any_g,
    input logic       ev_any_h,
    input logic       ev_lane_both,
    input logic       ev_either
);
    a_r10_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid |=> (g_match == 4'd0 && h_match == 4'd0 && !ev_either));

    a_r8_g_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && size_rank(cyc_size) < size_rank(g_csize)) |=> g_match == 4'd0);

    a_r8_h_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && size_rank(cyc_size) < size_rank(h_csize)) |=> h_match == 4'd0);

    a_r7_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_size == 2'd0) |=> ($onehot0(g_match) && $onehot0(h_match)));

    a_r9_event_g: assert property (@(posedge clk) disable iff (!rst_n)
        ev_any_g == (g_match != 4'd0));

    a_r9_event_both: assert property (@(posedge clk) disable iff (!rst_n)
        ev_lane_both |-> (ev_any_g && ev_any_h && ev_either));

    a_r9_event_h: assert property (@(posedge clk) disable iff (!rst_n)
        ev_any_h == (h_match != 4'd0));
endmodule

bind dwp_datacmp dwp_datacmp_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_valid   (cyc_valid),
    .cyc_size    (cyc_size),
    .g_csize     (g_csize),
    .h_csize     (h_csize),
    .g_match     (g_match),
    .h_match     (h_match),
    .ev_any_g    (ev_any_g),
    .ev_any_h    (ev_any_h),
    .ev_lane_both(ev_lane_both),
    .ev_either   (ev_either)
);

// File: tb/dwp_datacmp_tb.sv
module dwp_datacmp_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_valid = 1'b0;
    logic [31:0] cyc_data = '0;
    logic [1:0]  cyc_addr = '0;
    logic [1:0]  cyc_size = '0;
    logic [31:0] g_ref = '0, h_ref = '0;
    logic [3:0]  g_mask = '0, h_mask = '0;
    logic        g_signed = 1'b0, h_signed = 1'b0;
    logic [1:0]  g_csize = '0, h_csize = '0, g_ctype = '0, h_ctype = '0;
    logic [3:0]  g_match, h_match;
    logic        ev_any_g, ev_any_h, ev_lane_both, ev_either;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] lcg = 32'h1234_5678;

    always #5 clk = ~clk;

    dwp_datacmp u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_data(cyc_data),
        .cyc_addr(cyc_addr), .cyc_size(cyc_size),
        .g_ref(g_ref), .g_mask(g_mask), .g_signed(g_signed), .g_csize(g_csize), .g_ctype(g_ctype),
        .h_ref(h_ref), .h_mask(h_mask), .h_signed(h_signed), .h_csize(h_csize), .h_ctype(h_ctype),
        .g_match(g_match), .h_match(h_match), .ev_any_g(ev_any_g), .ev_any_h(ev_any_h),
        .ev_lane_both(ev_lane_both), .ev_either(ev_either)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    // Arithmetic model: masked bytes become zero on both sides, each unit is an integer.
    function automatic logic [3:0] model(input logic [31:0] d, input logic [31:0] r,
                                         input logic [3:0] m, input logic s,
                                         input logic [1:0] cs, input logic [1:0] ct,
                                         input logic [1:0] cz, input logic [1:0] ad);
        logic [31:0] dz, rz;
        logic [3:0]  res;
        int rc, ry, w, lo;
        longint a, b;
        logic eq, lt, hit, vld;
        rc = cs[1] ? 2 : int'(cs);
        ry = cz[1] ? 2 : int'(cz);
        dz = d;
        rz = r;
        for (int k = 0; k < 4; k++) begin
            if (m[k]) begin
                dz[31-8*k -: 8] = 8'h00;
                rz[31-8*k -: 8] = 8'h00;
            end
        end
        for (int l = 0; l < 4; l++) begin
            w  = (rc == 0) ? 8 : (rc == 1) ? 16 : 32;
            lo = (rc == 0) ? 24 - 8*l : (rc == 1) ? 16 - 16*(l/2) : 0;
            a = longint'(dz >> lo) & ((longint'(1) << w) - 1);
            b = longint'(rz >> lo) & ((longint'(1) << w) - 1);
            if (s && a >= (longint'(1) << (w-1))) a = a - (longint'(1) << w);
            if (s && b >= (longint'(1) << (w-1))) b = b - (longint'(1) << w);
            eq = (a == b);
            lt = (a < b);
            case (ct)
                2'd0: hit = eq;
                2'd1: hit = !eq;
                2'd2: hit = a > b;
                default: hit = lt;
            endcase
            vld = (ry == 0) ? (l == int'(ad)) : (ry == 1) ? ((l/2) == int'(ad[1])) : 1'b1;
            if (ry < rc) vld = 1'b0;
            res[l] = hit && vld;
        end
        return res;
    endfunction

    function automatic string tag_for(input logic [1:0] cz, input logic [1:0] cs,
                                      input logic [3:0] m, input logic s);
        int rc, ry;
        rc = cs[1] ? 2 : int'(cs);
        ry = cz[1] ? 2 : int'(cz);
        if (ry < rc)       return "R8";
        if (m != 4'd0)     return "R5 R6 R7";
        if (s)             return "R4 R6 R7";
        if (rc != 0)       return "R3 R6 R7";
        return "R2 R6 R7";
    endfunction

    task automatic run_cycle(input int p);
        logic [3:0] eg, eh;
        cyc_valid = 1'b1;
        @(negedge clk);
        eg = model(cyc_data, g_ref, g_mask, g_signed, g_csize, g_ctype, cyc_size, cyc_addr);
        eh = model(cyc_data, h_ref, h_mask, h_signed, h_csize, h_ctype, cyc_size, cyc_addr);
        chk({"G ", tag_for(cyc_size, g_csize, g_mask, g_signed)}, g_match, eg);
        chk({"H ", tag_for(cyc_size, h_csize, h_mask, h_signed)}, h_match, eh);
        chk("R9 events", {ev_any_g, ev_any_h, ev_lane_both, ev_either},
            {|eg, |eh, |(eg & eh), |(eg | eh)});
        if (p < 0) $display("unused");
    endtask

    initial begin : watchdog
        #(1_500_000ns);
        n_bad++;
        n_chk++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : stim
        @(negedge clk);
        // R1: reset holds outputs low even with a matching strobe present.
        cyc_valid = 1'b1;
        cyc_size  = 2'd2;
        g_ctype   = 2'd0;
        h_ctype   = 2'd0;
        @(negedge clk);
        chk("R1 reset g", g_match, 4'd0);
        chk("R1 reset h", h_match, 4'd0);
        chk("R1 reset ev", {ev_any_g, ev_any_h, ev_lane_both, ev_either}, 4'd0);
        cyc_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", g_match | h_match, 4'd0);

        for (int cz = 0; cz < 4; cz++) begin
            for (int ad = 0; ad < 4; ad++) begin
                for (int cs = 0; cs < 3; cs++) begin
                    for (int ct = 0; ct < 4; ct++) begin
                        for (int sg = 0; sg < 2; sg++) begin
                            for (int p = 0; p < 8; p++) begin
                                cyc_size = 2'(cz);
                                cyc_addr = 2'(ad);
                                g_csize  = 2'(cs);
                                g_ctype  = 2'(ct);
                                g_signed = sg[0];
                                h_csize  = 2'((cs + p) % 4);
                                h_ctype  = 2'((ct + 1) % 4);
                                h_signed = !sg[0];
                                cyc_data = next_rand();
                                g_ref    = p[0] ? (cyc_data ^ (32'h80 << (8 * (p % 4))))
                                                : next_rand();
                                h_ref    = (p % 3 == 0) ? cyc_data
                                                        : (cyc_data + 32'(p * 32'h0101));
                                g_mask   = (p > 3) ? 4'(p * 5) : 4'd0;
                                h_mask   = 4'((p * 3) % 16);
                                run_cycle(p);
                            end
                            // R10: no strobe gives zeros on the next edge.
                            cyc_valid = 1'b0;
                            @(negedge clk);
                            chk("R10 idle", g_match | h_match, 4'd0);
                        end
                    end
                end
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule